// File: doc/BRIEF.md
# Frame-Synchronised Configuration Shadow Controller

This block keeps an active copy of the configuration of each pipeline stage and decides in which cycle that copy takes over the value that software has placed in the stage's working register. Software writes a single control word through a simple write port. Its top two bits choose the commit policy: commit immediately, commit at every frame start, or commit once at the first frame start after software has asked for it. Its low bits carry one update request for each stage group.

There are seven stage groups. Each working register is presented on a wide input bus, and each active copy leaves on a matching output bus. The frame-start strobe is a synchronous level, and the block detects its rising edge itself. A strobe that is held high for many cycles therefore commits once. The pending requests are brought out so that the downstream logic, and a test, can see which stages still wait for a frame start.

Top module: `shadow_ctrl_top`

## Requirements
- R1: After reset every active copy is zero, no request is pending, and the policy is 1 (commit every frame start).
- R2: Under policy 0 every active copy equals the working value sampled at the previous clock edge. Frame starts and requests play no part in this.
- R3: Under policy 1, and under the spare code 3, every stage copies its working value at a clock edge where the strobe is high and was low at the edge before. At every other edge the active copies hold.
- R4: Under policy 2, a strobe rising edge copies only the stages whose request is pending. All other stages hold.
- R5: Writing 1 to bit 0, 1, 2, 3 or 4 of the control word requests stages 0 to 4, and writing 1 to bit 6 or 7 requests stages 5 and 6. Writing 0 to a bit leaves its request unchanged. Bit 5 is ignored and requests nothing.
- R6: At a strobe rising edge under policy 1, 2 or 3, every request that was pending before the edge is cleared. Under policy 0 the pending requests are held.
- R7: A request written in the same cycle as a strobe rising edge does not commit at that edge. It stays pending and commits at the next rising edge under policy 2.
- R8: A strobe held high over several edges commits only at its first edge. Working values that change while the strobe stays high do not reach the active copies.
- R9: The policy sits in control bits 31:30 and is updated by every write. A new policy governs from the edge after the write, and a strobe edge in the cycle of the write uses the old policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word: policy in bits 31:30, stage requests in low bits |
| vsync_i | input | 1 | Frame-start level, synchronous to clk |
| work_cfg_i | input | NUM_STG*CFG_W (112) | Working registers, stage i in bits i*CFG_W upward |
| act_cfg_o | output | NUM_STG*CFG_W (112) | Active copies, same packing |
| pend_o | output | NUM_STG (7) | Pending request per stage |

## Verification
The two functions that can fall in one cycle are a request write and a frame-start edge. The collision also occurs when a policy write meets a frame-start edge. Directed steps drive a write and a rising strobe into the same clock edge. The bench then checks two things: the edge follows the old policy and the old pending set, and the new request survives to the following edge. Random runs mix writes, strobe pulses of varying length and changing working values so that such collisions recur. Every cycle is compared against a bench model that applies the requirements in their stated order.

// File: rtl/shadow_pkg.sv
// Shared types and constants for the shadow controller.
// Assumes a 32-bit control word with the policy in its top two bits.
package shadow_pkg;
    typedef enum logic [1:0] {
        UPD_IMM     = 2'd0,
        UPD_VSYNC   = 2'd1,
        UPD_ONESHOT = 2'd2,
        UPD_SPARE   = 2'd3
    } upd_mode_e;

    localparam int CTRL_W   = 32;
    localparam int MODE_LSB = 30;
    localparam int RSV_BIT  = 5;

    // control-word bit that carries the request for stage idx
    function automatic int req_pos(input int idx);
        return (idx < RSV_BIT) ? idx : idx + 1;
    endfunction
endpackage

// File: rtl/shadow_vsync_edge.sv
// Rising-edge detector for the frame-start level.
// Assumes vsync_i is already synchronous to clk.
module shadow_vsync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_i,
    output logic rise_o
);
    logic vs_d;

    // remember last sampled strobe level
    always_ff @(posedge clk) begin
        if (!rst_n) vs_d <= 1'b0;
        else        vs_d <= vsync_i;
    end

    assign rise_o = vsync_i & ~vs_d;
endmodule

// File: rtl/shadow_ctrl_reg.sv
// Control word: holds the commit policy and the per-stage pending requests.
// Assumes a write and a frame edge may share a cycle. The edge clears with the
// old policy and the new request is kept.
module shadow_ctrl_reg
    import shadow_pkg::*;
#(
    parameter int NUM_STG = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CTRL_W-1:0]  wr_data,
    input  logic               vs_rise_i,
    output upd_mode_e          mode_o,
    output logic [NUM_STG-1:0] req_o,
    output logic [NUM_STG-1:0] pend_o
);
    function automatic logic [CTRL_W-1:0] used_mask();
        logic [CTRL_W-1:0] m;
        m = '0;
        m[CTRL_W-1:MODE_LSB] = '1;
        for (int i = 0; i < NUM_STG; i++) m[req_pos(i)] = 1'b1;
        return m;
    endfunction

    localparam logic [CTRL_W-1:0] USED_MASK = used_mask();

    upd_mode_e          mode_q;
    logic [NUM_STG-1:0] pend_q;
    logic               unused_bits;

    assign unused_bits = ^(wr_data & ~USED_MASK);

    // gather request bits from their control-word positions
    always_comb begin
        req_o = '0;
        for (int i = 0; i < NUM_STG; i++)
            req_o[i] = wr_en & wr_data[req_pos(i)];
    end

    // policy register, loaded by every write
    always_ff @(posedge clk) begin
        if (!rst_n)     mode_q <= UPD_VSYNC;
        else if (wr_en) mode_q <= upd_mode_e'(wr_data[CTRL_W-1:MODE_LSB]);
    end

    // pending requests: cleared by a committing edge, set by new writes
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else if (vs_rise_i && mode_q != UPD_IMM) pend_q <= req_o;
        else pend_q <= pend_q | req_o;
    end

    assign mode_o = mode_q;
    assign pend_o = pend_q;
endmodule

// File: rtl/shadow_stage.sv
// Active copy of one stage's configuration and its commit decision.
// Assumes the policy and pending inputs are the values before the current edge.
module shadow_stage
    import shadow_pkg::*;
#(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  upd_mode_e        mode_i,
    input  logic             vs_rise_i,
    input  logic             pend_i,
    input  logic [CFG_W-1:0] work_i,
    output logic [CFG_W-1:0] act_o
);
    logic commit;

    // decide whether this edge loads the working value
    always_comb begin
        unique case (mode_i)
            UPD_IMM:     commit = 1'b1;
            UPD_ONESHOT: commit = vs_rise_i & pend_i;
            default:     commit = vs_rise_i;
        endcase
    end

    // active copy register
    always_ff @(posedge clk) begin
        if (!rst_n)      act_o <= '0;
        else if (commit) act_o <= work_i;
    end
endmodule

// File: rtl/shadow_ctrl_top.sv
// Shadow register controller top: edge detector, control word, one active copy per stage.
// Assumes all inputs are synchronous to clk.
module shadow_ctrl_top
    import shadow_pkg::*;
#(
    parameter int NUM_STG = 7,
    parameter int CFG_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [31:0]              wr_data,
    input  logic                     vsync_i,
    input  logic [NUM_STG*CFG_W-1:0] work_cfg_i,
    output logic [NUM_STG*CFG_W-1:0] act_cfg_o,
    output logic [NUM_STG-1:0]       pend_o
);
    logic               vs_rise;
    upd_mode_e          mode_q;
    logic [NUM_STG-1:0] req_vec;

    shadow_vsync_edge edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .vsync_i (vsync_i),
        .rise_o  (vs_rise)
    );

    shadow_ctrl_reg #(.NUM_STG(NUM_STG)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .vs_rise_i (vs_rise),
        .mode_o    (mode_q),
        .req_o     (req_vec),
        .pend_o    (pend_o)
    );

    for (genvar g = 0; g < NUM_STG; g++) begin : g_stage
        shadow_stage #(.CFG_W(CFG_W)) stage_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_i    (mode_q),
            .vs_rise_i (vs_rise),
            .pend_i    (pend_o[g]),
            .work_i    (work_cfg_i[g*CFG_W +: CFG_W]),
            .act_o     (act_cfg_o[g*CFG_W +: CFG_W])
        );
    end
endmodule

// File: rtl/shadow_ctrl_chk.sv
// Assertion checker for shadow_ctrl_top, attached by bind.
// Assumes synchronous active-low reset.
module shadow_ctrl_chk #(
    parameter int NUM_STG = 7,
    parameter int CFG_W   = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     vsync_i,
    input logic [1:0]               mode_q,
    input logic [NUM_STG-1:0]       req_vec,
    input logic [NUM_STG-1:0]       pend_o,
    input logic [NUM_STG*CFG_W-1:0] work_cfg_i,
    input logic [NUM_STG*CFG_W-1:0] act_cfg_o
);
    logic vs_prev;

    // independent strobe history for the checker
    always_ff @(posedge clk) begin
        if (!rst_n) vs_prev <= 1'b0;
        else        vs_prev <= vsync_i;
    end

    // R2
    imm_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == 2'd0 |=> act_cfg_o == $past(work_cfg_i));

    // R3
    hold_between_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != 2'd0 && !(vsync_i && !vs_prev)) |=> $stable(act_cfg_o));

    // R4
    oneshot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd2 && pend_o == '0) |=> $stable(act_cfg_o));

    // R6
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_i && !vs_prev && mode_q != 2'd0) |=> pend_o == $past(req_vec));

    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == 2'd0 |=> (pend_o & $past(pend_o)) == $past(pend_o));

    // R8
    held_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_i && vs_prev && mode_q != 2'd0) |=> $stable(act_cfg_o));
endmodule

bind shadow_ctrl_top shadow_ctrl_chk #(.NUM_STG(NUM_STG), .CFG_W(CFG_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .vsync_i    (vsync_i),
    .mode_q     (mode_q),
    .req_vec    (req_vec),
    .pend_o     (pend_o),
    .work_cfg_i (work_cfg_i),
    .act_cfg_o  (act_cfg_o)
);

// File: tb/shadow_ctrl_top_tb.sv
`timescale 1ns/1ps
// Bench for shadow_ctrl_top: directed collisions plus seeded random traffic.
module shadow_ctrl_top_tb_top;
    localparam int NUM_STG = 7;
    localparam int CFG_W   = 16;
    localparam int TOT     = NUM_STG * CFG_W;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           wr_en;
    logic [31:0]    wr_data;
    logic           vsync_i;
    logic [TOT-1:0] work_cfg_i;
    logic [TOT-1:0] act_cfg_o;
    logic [NUM_STG-1:0] pend_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [1:0]         mode_m;
    logic [NUM_STG-1:0] pend_m;
    logic [TOT-1:0]     act_m;
    logic               vs_m;

    shadow_ctrl_top #(.NUM_STG(NUM_STG), .CFG_W(CFG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .vsync_i(vsync_i), .work_cfg_i(work_cfg_i),
        .act_cfg_o(act_cfg_o), .pend_o(pend_o)
    );

    always #5 clk = ~clk;

    // R5 map: stages 0-4 on bits 0-4, stages 5 and 6 on bits 6 and 7
    function automatic logic [NUM_STG-1:0] req_of(input logic [31:0] d);
        logic [NUM_STG-1:0] r;
        for (int i = 0; i < NUM_STG; i++) r[i] = (i < 5) ? d[i] : d[i+1];
        return r;
    endfunction

    function automatic logic [TOT-1:0] rnd_work();
        logic [TOT-1:0] w;
        for (int i = 0; i < 4; i++) w[i*32 +: 32] = $urandom;
        return w;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one clock: drive inputs, advance the model, compare at the next falling edge
    task automatic step(input bit we, input logic [31:0] d, input bit vs,
                        input logic [TOT-1:0] w, input string tag);
        logic edge_m;
        wr_en = we; wr_data = d; vsync_i = vs; work_cfg_i = w;
        edge_m = vs & ~vs_m;
        for (int i = 0; i < NUM_STG; i++)
            if (mode_m == 2'd0 || (edge_m && (mode_m != 2'd2 || pend_m[i])))
                act_m[i*CFG_W +: CFG_W] = w[i*CFG_W +: CFG_W];
        if (edge_m && mode_m != 2'd0) pend_m = '0;
        if (we) begin
            pend_m = pend_m | req_of(d);
            mode_m = d[31:30];
        end
        vs_m = vs;
        @(negedge clk);
        check(tag, "act", act_cfg_o, act_m);
        check(tag, "pend", TOT'(pend_o), TOT'(pend_m));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [TOT-1:0] w;
        int seed;
        seed = $urandom(32'd4242);
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; vsync_i = 1'b0; work_cfg_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mode_m = 2'd1; pend_m = '0; act_m = '0; vs_m = 1'b0;
        // R1 reset state
        check("R1", "act", act_cfg_o, '0);
        check("R1", "pend", TOT'(pend_o), '0);
        w = rnd_work();
        // R1: default policy 1 must not copy without an edge
        step(0, 0, 0, w, "R1");
        // R3 every-edge copy under default policy
        step(0, 0, 1, w, "R3");
        // R8 held strobe with changing working values
        step(0, 0, 1, rnd_work(), "R8");
        step(0, 0, 1, rnd_work(), "R8");
        step(0, 0, 0, rnd_work(), "R8");
        // R5 bit 5 ignored, policy 2
        step(1, 32'h8000_0020, 0, rnd_work(), "R5");
        step(1, 32'h8000_0001, 0, rnd_work(), "R5");
        step(1, 32'h8000_0000, 0, rnd_work(), "R5");
        step(1, 32'h8000_00C0, 0, rnd_work(), "R5");
        // R4 and R6 one-shot commit of stages 0, 5, 6
        step(0, 0, 1, rnd_work(), "R4");
        step(0, 0, 0, rnd_work(), "R6");
        // R7 request in the same cycle as the edge
        step(1, 32'h8000_0002, 1, rnd_work(), "R7");
        step(0, 0, 0, rnd_work(), "R7");
        step(0, 0, 1, rnd_work(), "R7");
        step(0, 0, 0, rnd_work(), "R7");
        // R9 policy change at an edge uses the old policy
        step(1, 32'h0000_0000, 1, rnd_work(), "R9");
        step(0, 0, 0, rnd_work(), "R9");
        // R2 immediate follow, R6 requests held under policy 0
        step(1, 32'h0000_0004, 0, rnd_work(), "R2");
        step(0, 0, 1, rnd_work(), "R6");
        step(0, 0, 0, rnd_work(), "R2");
        // R3 spare code 3 acts as every-edge
        step(1, 32'hC000_0000, 0, rnd_work(), "R3");
        step(0, 0, 1, rnd_work(), "R3");
        step(0, 0, 0, rnd_work(), "R3");
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            bit we;
            bit vs;
            logic [31:0] d;
            string tag;
            we = ($urandom % 5) == 0;
            d = $urandom;
            if (($urandom % 3) != 0) d[31:30] = 2'd2;
            vs = (($urandom % 4) == 0) ? ~vs_m : vs_m;
            tag = (mode_m == 2'd0) ? "R2" : (mode_m == 2'd2) ? "R4" : "R3";
            step(we, d, vs, (($urandom % 2) == 0) ? rnd_work() : work_cfg_i, tag);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule